// File: doc/BRIEF.md
# Instruction Loader with Opcode Group Classification

This block sits between a byte-wide instruction queue and a microcode sequencer. It does not work out an instruction's length before it starts. It takes the opcode and looks up a two-bit group for it in a table. According to that group it takes either one byte or two bytes (opcode plus ModR/M) from the queue. After that, one of three things happens:

- The instruction completes at once because logic executes it.
- The byte is a prefix, so the loader goes on to fetch the next opcode with the prefix marked as in effect.
- The loader starts the sequencer.

A running sequencer pulls any further bytes it needs, such as immediates or displacements, one at a time through the loader. A done pulse from the sequencer closes the instruction. The loader then reports the instruction's opcode, its total byte count and its prefix flag.

The group table is a parameter. By default the two top opcode bits select the group, which lets tests pick any class through the opcode value. The sequencer itself lives outside the block. The bench plays its part.

The control is a three-state machine:

- `ST_OPCODE` waits for an opcode byte. On a logic opcode it finishes and stays. On a prefix it records the flag and stays. On a plain microcoded opcode it moves to `ST_RUN`. On a ModR/M opcode it moves to `ST_MODRM`.
- `ST_MODRM` waits for the second byte, then moves to `ST_RUN`.
- `ST_RUN` forwards queue bytes while the sequencer requests them. It returns to `ST_OPCODE` on the done pulse.

Top module: `instld_loader`

## Requirements
- R1: The default group of an opcode comes from its bits [7:6]: 00 selects logic-executed, 01 selects prefix, 10 selects microcoded, and 11 selects microcoded with ModR/M. The GROUP_TABLE parameter can override this mapping for any opcode.
- R2: A logic-group opcode uses one byte. In the cycle after the byte is accepted, `exec_pulse` and `instr_done` pulse together. `seq_start` does not pulse.
- R3: A prefix-group byte uses one byte and does not complete an instruction. The next byte is fetched as a new opcode. `instr_pfx` is 1 for the instruction that follows one or more prefixes, and 0 otherwise. Prefix bytes count toward `instr_len`.
- R4: A microcoded opcode uses one byte. `seq_start` pulses in the cycle after the byte is accepted, with `seq_op` holding the opcode.
- R5: A ModR/M-group opcode uses two bytes. `seq_start` pulses in the cycle after the second byte is accepted, with `seq_modrm` holding that second byte.
- R6: While the sequencer runs, each byte accepted with `seq_req` high appears on `seq_data` with `seq_data_valid` high in the next cycle, in queue order.
- R7: In `ST_RUN`, `q_ready` is low unless `seq_req` is high and `seq_done` is low.
- R8: `seq_done` in `ST_RUN` produces an `instr_done` pulse in the next cycle. `instr_len` then equals all bytes taken for the instruction, and the loader is back in `ST_OPCODE`.
- R9: While `q_valid` is low, the loader holds its state and counts, so gaps in the queue do not change any reported result.
- R10: `instr_len` saturates at 2^LEN_W-1, which is 15 by default.
- R11: During and right after reset, `q_ready` is 1 and `instr_done`, `exec_pulse`, `seq_start` and `seq_data_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| q_valid | input | 1 | Queue offers a byte |
| q_byte | input | 8 | Queue byte |
| q_ready | output | 1 | Loader takes the offered byte this cycle |
| seq_start | output | 1 | Pulse: start the microcode sequencer |
| seq_op | output | 8 | Opcode of the current instruction |
| seq_modrm | output | 8 | ModR/M byte of the current instruction |
| seq_req | input | 1 | Sequencer wants a queue byte |
| seq_data | output | 8 | Byte forwarded to the sequencer |
| seq_data_valid | output | 1 | Pulse: `seq_data` is valid |
| seq_done | input | 1 | Sequencer has finished the instruction |
| exec_pulse | output | 1 | Pulse: logic-group instruction executed |
| instr_done | output | 1 | Pulse: instruction complete |
| instr_op | output | 8 | Opcode of the completed instruction |
| instr_len | output | 4 | Bytes consumed by the completed instruction |
| instr_pfx | output | 1 | A prefix was in effect for the completed instruction |

## Verification
Every result of the loader is registered, so each one shows up one cycle after the clock edge that caused it:

- `exec_pulse` and `instr_done` follow the edge that accepts a logic opcode.
- `seq_start` follows the edge that takes the last loader byte.
- `seq_data_valid` follows each edge that accepts a requested byte.
- `instr_done` follows the edge where `seq_done` is seen in the run state.

The bench drives inputs and reads outputs at the falling edge, half a cycle after the edge that produced them. Acceptance is recorded at the rising edge, so the feeder moves on only after a byte has actually been taken. The sequencer model drops its request in the same half cycle as the last `seq_data_valid`, so it never over-requests.

// File: rtl/instld_pkg.sv
package instld_pkg;

    localparam int OPC_W = 8;
    localparam int TBL_W = 2 * (1 << OPC_W);

    typedef enum logic [1:0] {
        GRP_LOGIC  = 2'd0,
        GRP_PREFIX = 2'd1,
        GRP_MICRO  = 2'd2,
        GRP_MODRM  = 2'd3
    } grp_e;

    typedef enum logic [1:0] {
        ST_OPCODE = 2'd0,
        ST_MODRM  = 2'd1,
        ST_RUN    = 2'd2
    } st_e;

    // Default group map: the two top opcode bits select the group.
    function automatic logic [TBL_W-1:0] default_table();
        logic [TBL_W-1:0] t;
        logic [OPC_W-1:0] b;
        t = '0;
        for (int i = 0; i < (1 << OPC_W); i++) begin
            b = OPC_W'(i);
            t[2*i +: 2] = b[OPC_W-1 -: 2];
        end
        return t;
    endfunction

endpackage

// File: rtl/instld_classify.sv
module instld_classify
    import instld_pkg::*;
#(
    parameter logic [TBL_W-1:0] TABLE = default_table()
) (
    input  logic [OPC_W-1:0] opcode,
    output grp_e             grp
);
    localparam int IDX_W = OPC_W + 1;

    logic [IDX_W-1:0] base;

    assign base = {opcode, 1'b0};
    assign grp  = grp_e'(TABLE[base +: 2]);

endmodule

// File: rtl/instld_lencnt.sv
module instld_lencnt #(
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             clr,
    output logic [LEN_W-1:0] cnt,
    output logic [LEN_W-1:0] sum
);
    localparam logic [LEN_W-1:0] MAX = {LEN_W{1'b1}};

    assign sum = (inc && cnt != MAX) ? cnt + 1'b1 : cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else          cnt <= sum;
    end

    a_r10_saturate : assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == MAX && !clr) |=> (cnt == MAX));

endmodule

// File: rtl/instld_ctrl.sv
module instld_ctrl
    import instld_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic q_valid,
    input  grp_e grp,
    input  logic seq_req,
    input  logic seq_done,
    output logic q_ready,
    output logic take,
    output logic ld_op,
    output logic ld_modrm,
    output logic set_pfx,
    output logic go_run,
    output logic fin,
    output logic fin_logic,
    output logic seq_take
);
    st_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_OPCODE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d   = state_q;
        q_ready   = 1'b0;
        ld_op     = 1'b0;
        ld_modrm  = 1'b0;
        set_pfx   = 1'b0;
        go_run    = 1'b0;
        fin       = 1'b0;
        fin_logic = 1'b0;
        seq_take  = 1'b0;
        unique case (state_q)
            ST_OPCODE: begin
                q_ready = 1'b1;
                if (q_valid) begin
                    ld_op = 1'b1;
                    unique case (grp)
                        GRP_LOGIC: begin
                            fin       = 1'b1;
                            fin_logic = 1'b1;
                        end
                        GRP_PREFIX: set_pfx = 1'b1;
                        GRP_MICRO: begin
                            go_run  = 1'b1;
                            state_d = ST_RUN;
                        end
                        GRP_MODRM: state_d = ST_MODRM;
                        default: ;
                    endcase
                end
            end
            ST_MODRM: begin
                q_ready = 1'b1;
                if (q_valid) begin
                    ld_modrm = 1'b1;
                    go_run   = 1'b1;
                    state_d  = ST_RUN;
                end
            end
            ST_RUN: begin
                q_ready  = seq_req && !seq_done;
                seq_take = q_valid && seq_req && !seq_done;
                if (seq_done) begin
                    fin     = 1'b1;
                    state_d = ST_OPCODE;
                end
            end
            default: state_d = ST_OPCODE;
        endcase
    end

    assign take = q_valid && q_ready;

    a_r8_done_to_idle : assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && seq_done) |=> (state_q == ST_OPCODE));

    a_r5_modrm_then_run : assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MODRM && q_valid) |=> (state_q == ST_RUN));

endmodule

// File: rtl/instld_loader.sv
module instld_loader
    import instld_pkg::*;
#(
    parameter int               LEN_W       = 4,
    parameter logic [TBL_W-1:0] GROUP_TABLE = default_table()
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             q_valid,
    input  logic [OPC_W-1:0] q_byte,
    output logic             q_ready,
    output logic             seq_start,
    output logic [OPC_W-1:0] seq_op,
    output logic [OPC_W-1:0] seq_modrm,
    input  logic             seq_req,
    output logic [OPC_W-1:0] seq_data,
    output logic             seq_data_valid,
    input  logic             seq_done,
    output logic             exec_pulse,
    output logic             instr_done,
    output logic [OPC_W-1:0] instr_op,
    output logic [LEN_W-1:0] instr_len,
    output logic             instr_pfx
);
    grp_e             grp;
    logic             take, ld_op, ld_modrm, set_pfx, go_run;
    logic             fin, fin_logic, seq_take;
    logic [LEN_W-1:0] cnt, sum;
    logic             pfx_q;

    instld_classify #(.TABLE(GROUP_TABLE)) u_class (
        .opcode (q_byte),
        .grp    (grp)
    );

    instld_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .q_valid   (q_valid),
        .grp       (grp),
        .seq_req   (seq_req),
        .seq_done  (seq_done),
        .q_ready   (q_ready),
        .take      (take),
        .ld_op     (ld_op),
        .ld_modrm  (ld_modrm),
        .set_pfx   (set_pfx),
        .go_run    (go_run),
        .fin       (fin),
        .fin_logic (fin_logic),
        .seq_take  (seq_take)
    );

    instld_lencnt #(.LEN_W(LEN_W)) u_len (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (take),
        .clr   (fin),
        .cnt   (cnt),
        .sum   (sum)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_start      <= 1'b0;
            exec_pulse     <= 1'b0;
            instr_done     <= 1'b0;
            seq_data_valid <= 1'b0;
            seq_data       <= '0;
            seq_op         <= '0;
            seq_modrm      <= '0;
            pfx_q          <= 1'b0;
            instr_op       <= '0;
            instr_len      <= '0;
            instr_pfx      <= 1'b0;
        end else begin
            seq_start      <= go_run;
            exec_pulse     <= fin_logic;
            instr_done     <= fin;
            seq_data_valid <= seq_take;
            if (seq_take) seq_data  <= q_byte;
            if (ld_op)    seq_op    <= q_byte;
            if (ld_modrm) seq_modrm <= q_byte;
            if (fin)          pfx_q <= 1'b0;
            else if (set_pfx) pfx_q <= 1'b1;
            if (fin) begin
                instr_op  <= fin_logic ? q_byte : seq_op;
                instr_len <= sum;
                instr_pfx <= pfx_q;
            end
        end
    end

    a_r2_exec_with_done : assert property (@(posedge clk) disable iff (!rst_n)
        exec_pulse |-> instr_done);

    a_r4_start_follows_take : assert property (@(posedge clk) disable iff (!rst_n)
        seq_start |-> $past(q_valid && q_ready));

    a_r4_start_single : assert property (@(posedge clk) disable iff (!rst_n)
        seq_start |=> !seq_start);

    a_r6_data_needs_req : assert property (@(posedge clk) disable iff (!rst_n)
        seq_data_valid |-> $past(seq_req));

    a_r7_no_start_and_data : assert property (@(posedge clk) disable iff (!rst_n)
        !(seq_start && seq_data_valid));

    a_r8_len_nonzero : assert property (@(posedge clk) disable iff (!rst_n)
        instr_done |-> (instr_len != '0));

endmodule

// File: tb/instld_loader_test.sv
module instld_loader_test;

    localparam int CLK_PER = 10;
    localparam int NV      = 11;

    localparam logic [7:0] V_NP  [NV] = '{8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd1, 8'd2, 8'd0, 8'd1, 8'd20, 8'd0};
    localparam logic [7:0] V_OP  [NV] = '{8'h12, 8'h82, 8'hC2, 8'h80, 8'hC0, 8'h05, 8'hC3, 8'hBF, 8'h81, 8'h01, 8'h3F};
    localparam logic [3:0] V_LEN [NV] = '{4'd1, 4'd3, 4'd4, 4'd1, 4'd2, 4'd2, 4'd7, 4'd4, 4'd3, 4'd15, 4'd1};
    localparam bit         V_PFX [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0};
    localparam bit         V_LOG [NV] = '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       q_valid = 1'b0;
    logic [7:0] q_byte = 8'h00;
    logic       q_ready;
    logic       seq_start;
    logic [7:0] seq_op, seq_modrm;
    logic       seq_req = 1'b0;
    logic [7:0] seq_data;
    logic       seq_data_valid;
    logic       seq_done = 1'b0;
    logic       exec_pulse, instr_done;
    logic [7:0] instr_op;
    logic [3:0] instr_len;
    logic       instr_pfx;

    int checks = 0;
    int errors = 0;
    int nseen  = 0;
    bit wd_hit = 1'b0;
    logic [7:0] stream [256];
    int nstream = 0;
    int half = 0;
    logic acc = 1'b0;

    instld_loader uut (
        .clk(clk), .rst_n(rst_n), .q_valid(q_valid), .q_byte(q_byte), .q_ready(q_ready),
        .seq_start(seq_start), .seq_op(seq_op), .seq_modrm(seq_modrm), .seq_req(seq_req),
        .seq_data(seq_data), .seq_data_valid(seq_data_valid), .seq_done(seq_done),
        .exec_pulse(exec_pulse), .instr_done(instr_done), .instr_op(instr_op),
        .instr_len(instr_len), .instr_pfx(instr_pfx)
    );

    always #(CLK_PER/2) clk = ~clk;

    always @(posedge clk) acc <= q_valid && q_ready;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic feeder();
        int p = 0;
        int c = 0;
        forever begin
            @(negedge clk);
            if (acc) p++;
            // R9: in the second pass the queue drops valid every fourth cycle
            if (p < nstream && !(p >= half && (c % 4) == 1)) begin
                q_valid = 1'b1;
                q_byte  = stream[p];
            end else begin
                q_valid = 1'b0;
            end
            c++;
        end
    endtask

    task automatic sequencer();
        bit active = 1'b0;
        int rem = 0;
        int k = 0;
        logic [7:0] eop;
        forever begin
            @(negedge clk);
            if (seq_start) begin
                eop = V_OP[nseen % NV];
                chk(seq_op == eop, "R4 seq_op", int'(seq_op), int'(eop));
                if (eop[7:6] == 2'b11)
                    chk(seq_modrm == 8'h5A, "R5 seq_modrm", int'(seq_modrm), 'h5A);
                chk(q_ready == 1'b0, "R7 q_ready idle run", int'(q_ready), 0);
                active = 1'b1;
                rem = int'(seq_op[1:0]);
                k = 0;
                if (rem == 0) seq_done = 1'b1;
                else          seq_req  = 1'b1;
            end else if (active) begin
                if (seq_done) begin
                    seq_done = 1'b0;
                    active = 1'b0;
                end else if (seq_data_valid) begin
                    chk(seq_data == 8'(8'hE0 + k), "R6 seq_data", int'(seq_data), 'hE0 + k);
                    k++;
                    rem--;
                    if (rem == 0) begin
                        seq_req  = 1'b0;
                        seq_done = 1'b1;
                    end
                end
            end
        end
    endtask

    task automatic monitor();
        int i;
        bit pass2;
        forever begin
            @(negedge clk);
            if (instr_done && nseen < 2*NV) begin
                i = nseen % NV;
                pass2 = (nseen >= NV);
                if (i == 9)
                    chk(instr_len == V_LEN[i], "R10 saturated length", int'(instr_len), int'(V_LEN[i]));
                else if (pass2)
                    chk(instr_len == V_LEN[i], "R9 length with gaps", int'(instr_len), int'(V_LEN[i]));
                else if (V_LOG[i])
                    chk(instr_len == V_LEN[i], "R2 logic length", int'(instr_len), int'(V_LEN[i]));
                else
                    chk(instr_len == V_LEN[i], "R8 micro length", int'(instr_len), int'(V_LEN[i]));
                chk(instr_pfx == V_PFX[i], "R3 prefix flag", int'(instr_pfx), int'(V_PFX[i]));
                chk(exec_pulse == V_LOG[i], "R1 group execute", int'(exec_pulse), int'(V_LOG[i]));
                chk(instr_op == V_OP[i], "R8 opcode", int'(instr_op), int'(V_OP[i]));
                nseen++;
            end
        end
    endtask

    initial begin
        for (int ps = 0; ps < 2; ps++) begin
            if (ps == 1) half = nstream;
            for (int v = 0; v < NV; v++) begin
                for (int j = 0; j < int'(V_NP[v]); j++) stream[nstream++] = 8'(8'h40 + j);
                stream[nstream++] = V_OP[v];
                if (V_OP[v][7:6] == 2'b11) stream[nstream++] = 8'h5A;
                if (V_OP[v][7] == 1'b1)
                    for (int k = 0; k < int'(V_OP[v][1:0]); k++) stream[nstream++] = 8'(8'hE0 + k);
            end
        end

        repeat (3) @(negedge clk);
        chk(q_ready == 1'b1 && instr_done == 1'b0 && seq_start == 1'b0 && exec_pulse == 1'b0,
            "R11 in reset", int'({q_ready, instr_done, seq_start, exec_pulse}), 'b1000);
        rst_n = 1'b1;
        @(negedge clk);
        chk(q_ready == 1'b1 && seq_data_valid == 1'b0, "R11 after reset",
            int'({q_ready, seq_data_valid}), 'b10);

        fork
            feeder();
            sequencer();
            monitor();
            begin
                for (int c = 0; c < 5000; c++) @(negedge clk);
                wd_hit = 1'b1;
            end
        join_none

        wait (nseen == 2*NV || wd_hit);
        if (wd_hit) chk(1'b0, "R8 watchdog expired", nseen, 2*NV);

        repeat (3) @(negedge clk);
        chk(instr_done == 1'b0 && exec_pulse == 1'b0, "R9 idle after stream",
            int'({instr_done, exec_pulse}), 0);
        rst_n = 1'b0;
        @(negedge clk);
        chk(q_ready == 1'b1 && instr_done == 1'b0 && seq_start == 1'b0,
            "R11 mid-run reset", int'({q_ready, instr_done, seq_start}), 'b100);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule